// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter with a power-of-two timeout period and an optional clear window. The counter advances once for every cycle in which the tick enable is high. The tick enable comes from whatever clock source the surrounding logic selects. Run mode and sleep mode each have their own 5-bit period code, and the sleep input chooses which code applies. Software must service the watchdog by pulsing a clear strobe. When window checking is on, the clear counts only if it arrives in the final part of the period. That part is one of four selectable fractions. A clear that comes too early is treated as a failure, the same as a timeout.

A failure produces one of two requests, chosen by a configuration bit. A reset request halts the block until the device reset arrives. A trap request restarts the count so that software can recover. The block runs when a hardware force bit or a software on bit is set. It can hold its count while non-volatile programming is in progress.

The control is a four-state machine. OFF means disabled, with the count idle. RUN means counting. FROZEN means enabled but held by programming. HALT means a reset request has been issued.

The transitions are:

- OFF to RUN on enable, with the count set to zero.
- RUN or FROZEN back to OFF when the enable drops.
- RUN to FROZEN while the freeze condition holds.
- FROZEN to RUN when the freeze condition ends.
- RUN to RUN on a trap, with the count set to zero.
- RUN to HALT on a failure while reset is selected.
- HALT stays in HALT until the reset input.

Top module: `wdt_window_top`

## Requirements
- R1: With an effective period code N, the period P is 2^N ticks. A code of 0 acts as code 1, giving P = 2. A timeout fires on the tick that arrives while the count equals P-1. If the tick is held high from the enable cycle, the request output rises after the (P+1)-th clock edge counted from the enable edge.
- R2: When sleep is 1, the sleep period code is used. When sleep is 0, the run period code is used.
- R3: With window checking on (win_dis = 0), a clear at count c is accepted only if c >= k*P/8. The value of k is 6 for win_sel = 3 (last 25%), 5 for 2 (last 37.5%), 4 for 1 (last 50%) and 2 for 0 (last 75%).
- R4: With win_dis = 1, a clear is accepted at any count.
- R5: A clear that is not accepted is a failure. The request output rises after the clock edge that sampled that clear.
- R6: A failure pulses reset_req when rst_en = 1 and trap_req when rst_en = 0, never both. After reset_req, no further request occurs until rst_n is asserted.
- R7: While freeze_en = 1 and prog_busy = 1, the count holds, so each such cycle delays the timeout by one cycle. With freeze_en = 0, prog_busy has no effect.
- R8: The block runs when hw_en or sw_on is 1. With both at 0, no request is ever raised.
- R9: Each request is high for exactly one cycle. After a trap the count restarts from zero, so the next trap follows P edges later.
- R10: A change of period code or of the sleep input takes effect only at the next accepted clear, the next trap or the next enable.
- R11: An accepted clear sets the count to zero, so the next timeout follows P edges after the clear edge.
- R12: After reset, both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the selected time base |
| hw_en | input | 1 | Force the watchdog on |
| sw_on | input | 1 | Software on bit, used when hw_en is 0 |
| sleep | input | 1 | Selects the sleep period code |
| prog_busy | input | 1 | Non-volatile programming in progress |
| freeze_en | input | 1 | Hold the count during programming |
| rst_en | input | 1 | 1: failure requests a reset, 0: requests a trap |
| win_dis | input | 1 | 1 disables window checking |
| win_sel | input | 2 | Window fraction select |
| run_code | input | CODE_W | Run-mode period code |
| slp_code | input | CODE_W | Sleep-mode period code |
| clr | input | 1 | Watchdog clear strobe |
| reset_req | output | 1 | One-cycle reset request |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The count and the state are not visible at the ports, so a wrong internal value shows up only as a request that fires at the wrong edge. An off-by-one in the counter or in the terminal compare shifts the timeout by one edge. The bench catches that at the first timeout, within P+1 cycles of enabling. A wrong window threshold makes a clear at the boundary count give the wrong result. The clear-position sweep detects this on the same edge as the clear. A stuck state shows up as a missing or repeated request within one period.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_FROZEN = 2'd2,
        ST_HALT   = 2'd3
    } wdt_state_e;

    // Numerator in eighths of the period at which the clear window opens.
    function automatic logic [2:0] win_eighths(input logic [1:0] sel);
        logic [2:0] k;
        unique case (sel)
            2'b11: k = 3'd6;
            2'b10: k = 3'd5;
            2'b01: k = 3'd4;
            default: k = 3'd2;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/wdt_win_calc.sv
`timescale 1ns/1ps
module wdt_win_calc #(
    parameter int CODE_W = 5,
    parameter int CNT_W  = 31
) (
    input  logic [CODE_W-1:0] n_act,
    input  logic [1:0]        win_sel,
    output logic [CNT_W-1:0]  term_cnt,
    output logic [CNT_W-1:0]  win_thr
);
    import wdt_pkg::*;

    localparam int EXT_W = CNT_W + 4;

    logic [EXT_W-1:0] span;
    logic [EXT_W-1:0] scaled;

    always_comb begin
        span     = EXT_W'(1) << n_act;
        term_cnt = CNT_W'(span - EXT_W'(1));
        scaled   = span * EXT_W'(win_eighths(win_sel));
        win_thr  = CNT_W'(scaled >> 3);
    end

endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_zero,
    input  logic             cnt_inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_zero) begin
            cnt <= '0;
        end else if (cnt_inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
`timescale 1ns/1ps
module wdt_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                frz,
    input  logic                tick,
    input  logic                clr,
    input  logic                at_term,
    input  logic                in_win,
    input  logic                win_dis,
    input  logic                rst_en,
    output wdt_pkg::wdt_state_e state,
    output logic                cnt_zero,
    output logic                cnt_inc,
    output logic                latch_code,
    output logic                reset_req,
    output logic                trap_req
);
    import wdt_pkg::*;

    wdt_state_e state_nx;
    logic       fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        cnt_zero   = 1'b0;
        cnt_inc    = 1'b0;
        latch_code = 1'b0;
        fire       = 1'b0;
        unique case (state)
            ST_OFF: begin
                if (en) begin
                    state_nx   = ST_RUN;
                    cnt_zero   = 1'b1;
                    latch_code = 1'b1;
                end
            end
            ST_RUN, ST_FROZEN: begin
                if (!en) begin
                    state_nx = ST_OFF;
                end else if (frz) begin
                    state_nx = ST_FROZEN;
                end else begin
                    state_nx = ST_RUN;
                    if (clr) begin
                        if (win_dis || in_win) begin
                            cnt_zero   = 1'b1;
                            latch_code = 1'b1;
                        end else begin
                            fire = 1'b1;
                        end
                    end else if (tick) begin
                        if (at_term) begin
                            fire = 1'b1;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                    if (fire) begin
                        if (rst_en) begin
                            state_nx = ST_HALT;
                        end else begin
                            cnt_zero   = 1'b1;
                            latch_code = 1'b1;
                        end
                    end
                end
            end
            ST_HALT: begin
                state_nx = ST_HALT;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reset_req <= 1'b0;
            trap_req  <= 1'b0;
        end else begin
            reset_req <= fire && rst_en;
            trap_req  <= fire && !rst_en;
        end
    end

endmodule

// File: rtl/wdt_window_top.sv
`timescale 1ns/1ps
module wdt_window_top #(
    parameter int CODE_W = 5,
    parameter int CNT_W  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hw_en,
    input  logic              sw_on,
    input  logic              sleep,
    input  logic              prog_busy,
    input  logic              freeze_en,
    input  logic              rst_en,
    input  logic              win_dis,
    input  logic [1:0]        win_sel,
    input  logic [CODE_W-1:0] run_code,
    input  logic [CODE_W-1:0] slp_code,
    input  logic              clr,
    output logic              reset_req,
    output logic              trap_req
);
    import wdt_pkg::*;

    localparam int MAX_N = CNT_W;

    function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] r;
        if (c == '0) begin
            r = CODE_W'(1);
        end else if (int'(c) > MAX_N) begin
            r = CODE_W'(MAX_N);
        end else begin
            r = c;
        end
        return r;
    endfunction

    logic              wd_en;
    logic              wd_frz;
    logic [CODE_W-1:0] code_sel;
    logic [CODE_W-1:0] n_act;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  term_cnt;
    logic [CNT_W-1:0]  win_thr;
    logic              cnt_zero;
    logic              cnt_inc;
    logic              latch_code;
    wdt_state_e        fsm_state;

    assign wd_en    = hw_en || sw_on;
    assign wd_frz   = freeze_en && prog_busy;
    assign code_sel = sleep ? slp_code : run_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_act <= CODE_W'(1);
        end else if (latch_code) begin
            n_act <= eff_code(code_sel);
        end
    end

    wdt_win_calc #(.CODE_W(CODE_W), .CNT_W(CNT_W)) calc_i (
        .n_act    (n_act),
        .win_sel  (win_sel),
        .term_cnt (term_cnt),
        .win_thr  (win_thr)
    );

    wdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_zero (cnt_zero),
        .cnt_inc  (cnt_inc),
        .cnt      (cnt)
    );

    wdt_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (wd_en),
        .frz        (wd_frz),
        .tick       (tick),
        .clr        (clr),
        .at_term    (cnt == term_cnt),
        .in_win     (cnt >= win_thr),
        .win_dis    (win_dis),
        .rst_en     (rst_en),
        .state      (fsm_state),
        .cnt_zero   (cnt_zero),
        .cnt_inc    (cnt_inc),
        .latch_code (latch_code),
        .reset_req  (reset_req),
        .trap_req   (trap_req)
    );

endmodule

// File: rtl/wdt_window_chk.sv
`timescale 1ns/1ps
module wdt_window_chk #(
    parameter int CNT_W = 31
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hw_en,
    input logic                sw_on,
    input logic                freeze_en,
    input logic                prog_busy,
    input logic                clr,
    input logic                win_dis,
    input logic                reset_req,
    input logic                trap_req,
    input wdt_pkg::wdt_state_e state,
    input logic [CNT_W-1:0]    cnt,
    input logic [CNT_W-1:0]    term
);
    import wdt_pkg::*;

    logic live;
    assign live = (state == ST_RUN) || (state == ST_FROZEN);

    // R9
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R9
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    // R6
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_req && trap_req));

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && $past(state) == ST_HALT) |-> (!reset_req && !trap_req));

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (cnt <= term));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (hw_en || sw_on) && freeze_en && prog_busy) |=> $stable(cnt));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_en && !sw_on) |=> (!reset_req && !trap_req));

    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && (hw_en || sw_on) && !(freeze_en && prog_busy) && clr && win_dis)
        |=> (cnt == '0 && !trap_req && !reset_req));

endmodule

bind wdt_window_top wdt_window_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_en     (hw_en),
    .sw_on     (sw_on),
    .freeze_en (freeze_en),
    .prog_busy (prog_busy),
    .clr       (clr),
    .win_dis   (win_dis),
    .reset_req (reset_req),
    .trap_req  (trap_req),
    .state     (fsm_state),
    .cnt       (cnt),
    .term      (term_cnt)
);

// File: tb/wdt_window_top_tb_top.sv
`timescale 1ns/1ps
module wdt_window_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hw_en = 1'b0;
    logic       sw_on = 1'b0;
    logic       sleep = 1'b0;
    logic       prog_busy = 1'b0;
    logic       freeze_en = 1'b0;
    logic       rst_en = 1'b0;
    logic       win_dis = 1'b0;
    logic [1:0] win_sel = 2'b00;
    logic [4:0] run_code = 5'd1;
    logic [4:0] slp_code = 5'd1;
    logic       clr = 1'b0;
    logic       reset_req;
    logic       trap_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wdt_window_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hw_en(hw_en), .sw_on(sw_on),
        .sleep(sleep), .prog_busy(prog_busy), .freeze_en(freeze_en),
        .rst_en(rst_en), .win_dis(win_dis), .win_sel(win_sel),
        .run_code(run_code), .slp_code(slp_code), .clr(clr),
        .reset_req(reset_req), .trap_req(trap_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int limit, output int edges);
        edges = 0;
        do begin
            @(negedge clk);
            edges++;
        end while (!(trap_req || reset_req) && edges < limit);
    endtask

    task automatic disable_wd();
        @(negedge clk);
        hw_en = 1'b0; sw_on = 1'b0; clr = 1'b0; prog_busy = 1'b0;
        @(negedge clk);
    endtask

    function automatic int period_of(input int code);
        return 1 << ((code == 0) ? 1 : code);
    endfunction

    function automatic int eighths(input int sel);
        case (sel)
            3: return 6;
            2: return 5;
            1: return 4;
            default: return 2;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int e;
        tick = 1'b1;
        repeat (3) @(negedge clk);
        // R12
        check(!reset_req && !trap_req, "R12 reset state", {reset_req, trap_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R9 period per code, single-cycle pulse, restart after trap
        for (int code = 0; code <= 5; code++) begin
            disable_wd();
            run_code = 5'(code);
            hw_en = 1'b1;
            measure(200, e);
            check(e == period_of(code) + 1, "R1 first timeout", e, period_of(code) + 1);
            check(trap_req && !reset_req, "R6 trap selected", reset_req, 0);
            @(negedge clk);
            check(!trap_req, "R9 pulse width", trap_req, 0);
            measure(200, e);
            check(e == period_of(code) - 1, "R9 restart after trap", e, period_of(code) - 1);
        end

        // R2 sleep selects its own code
        disable_wd();
        run_code = 5'd2; slp_code = 5'd3; sleep = 1'b1; hw_en = 1'b1;
        measure(200, e);
        check(e == 9, "R2 sleep code", e, 9);
        disable_wd();
        sleep = 1'b0; hw_en = 1'b1;
        measure(200, e);
        check(e == 5, "R2 run code", e, 5);

        // R10 code change waits for restart
        disable_wd();
        run_code = 5'd2; hw_en = 1'b1;
        @(negedge clk); @(negedge clk);
        run_code = 5'd4;
        measure(200, e);
        check(e == 3, "R10 old period kept", e + 2, 5);
        measure(200, e);
        check(e == 16, "R10 new period after trap", e, 16);

        // R7 freeze holds; without freeze_en programming has no effect
        disable_wd();
        run_code = 5'd3; freeze_en = 1'b1; hw_en = 1'b1;
        repeat (3) @(negedge clk);
        prog_busy = 1'b1;
        repeat (5) @(negedge clk);
        prog_busy = 1'b0;
        measure(200, e);
        check(e + 8 == 14, "R7 freeze delays", e + 8, 14);
        disable_wd();
        freeze_en = 1'b0; hw_en = 1'b1; prog_busy = 1'b1;
        measure(200, e);
        check(e == 9, "R7 no freeze", e, 9);
        prog_busy = 1'b0;

        // R8 enable sources
        disable_wd();
        run_code = 5'd2;
        measure(40, e);
        check(e == 40 && !trap_req, "R8 disabled quiet", e, 40);
        sw_on = 1'b1;
        measure(200, e);
        check(e == 5, "R8 software on", e, 5);

        // R11 accepted clear zeroes count
        disable_wd();
        run_code = 5'd3; win_dis = 1'b1; hw_en = 1'b1;
        repeat (4) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(!trap_req, "R11 clear accepted", trap_req, 0);
        measure(200, e);
        check(e == 8, "R11 full period after clear", e, 8);

        // R4 window disabled: clear at count 0 accepted
        disable_wd();
        win_dis = 1'b1; hw_en = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clr = 1'b0;
        check(!trap_req, "R4 clear at zero", trap_req, 0);

        // R3, R5 sweep of clear position over codes and windows
        win_dis = 1'b0;
        for (int code = 1; code <= 4; code++) begin
            for (int sel = 0; sel < 4; sel++) begin
                for (int c = 0; c < period_of(code); c++) begin
                    int thr;
                    bit acc;
                    thr = (eighths(sel) * period_of(code)) / 8;
                    acc = (c >= thr);
                    disable_wd();
                    run_code = 5'(code); win_sel = 2'(sel); hw_en = 1'b1;
                    @(negedge clk);
                    repeat (c) @(negedge clk);
                    clr = 1'b1;
                    @(negedge clk);
                    clr = 1'b0;
                    check(trap_req == !acc, acc ? "R3 clear in window" : "R5 early clear",
                          trap_req, !acc);
                end
            end
        end

        // R6 reset request then silence until reset
        disable_wd();
        rst_en = 1'b1; run_code = 5'd2; hw_en = 1'b1;
        measure(200, e);
        check(e == 5 && reset_req && !trap_req, "R6 reset request", e, 5);
        measure(30, e);
        check(e == 30, "R6 halted quiet", e, 30);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; rst_en = 1'b0;
        @(negedge clk);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule